// File: doc/BRIEF.md
# Byte-Accessed Capture/Compare Timer

A 16-bit timer for a controller whose register bus is eight bits wide. A free-running up-counter advances once every four clocks. Two capture channels copy the counter on a chosen edge of an external pin. Two compare channels drive a chosen level onto a pin when the counter reaches a programmed value. A counter wrap also raises a flag. Each flag has its own enable bit, and the request line is the OR of the enabled flags. Software can use the wrap flag as a periodic tick, or use a compare channel to mark any multiple of four clocks.

Every 16-bit quantity appears as a high-byte register and a low-byte register. Touching the high byte puts that function on hold until its low byte is accessed, so a 16-bit value moves as one piece over the byte bus:
- A read of the counter's high byte freezes the low byte for the read that follows.
- A read of a capture high byte freezes that capture register.
- A write to a compare high byte stops matching on that channel.

A flag clears only when software has read the status register while the flag was set and then accesses the low byte that belongs to that flag.

Top module: `cc_timer`

## Requirements
- R1: The counter is 16 bits wide. It only ever steps by +1, and it wraps from 0xFFFF to 0x0000. Writes to the counter addresses (3 and 4) have no effect on it.
- R2: With the default prescale setting, the counter advances exactly once every four clock cycles. Two counter reads whose high-byte reads are N·4 cycles apart differ by exactly N.
- R3: A read of address 3 (counter high) returns the live high byte and buffers the live low byte. The next read of address 4 returns the buffered byte. Otherwise address 4 returns the live low byte. Reads never change the count.
- R4: A capture channel k latches the counter on its selected pin edge and sets status bit k. The counter value latched is the one returned by a counter read in the same cycle. CFG bit k selects the edge: 1 means rising, 0 means falling. The other edge is ignored.
- R5: From a read of a capture high byte (address 5 or 7) until the next access to its low byte (address 6 or 8), that capture register is frozen. Edges that arrive in this window are dropped and set no flag.
- R6: A write to a compare high byte (address 9 or 11) disables matching on that channel until its low byte (address 10 or 12) is written. Matching is disabled from reset until the first low-byte write.
- R7: When an enabled compare channel j sees the counter reach its value, status bit 2+j is set and pin cmp_o[j] takes CFG bit 2+j. Both stay until changed.
- R8: The counter wrapping from 0xFFFF to 0x0000 sets status bit 4.
- R9: irq_o is high exactly when some status bit is set whose enable bit is also set. The enable bits are IEN, address 0, bits [4:0], in the same positions as the status bits (status is address 2).
- R10: A status bit clears only when two steps happen in order. First, a read of address 2 sees the bit set. Then its low byte is read or written: address 6 for bit 0, 8 for bit 1, 10 for bit 2, 12 for bit 3, 4 for bit 4. A low-byte access with no such status read first leaves the bit set.
- R11: After reset:
  - IEN, CFG, status and both compare pins are 0.
  - irq_o is low.
  - Compare registers read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access; side effects take place at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| cap_i | input | 2 | Capture input pins, synchronous to clk_i |
| cmp_o | output | 2 | Compare output pins |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a capture edge that lands in the hold window, between a capture high-byte read and the matching low-byte read. The bench reads the high byte and then toggles the pin through a full edge. It then shows that the low byte, a fresh 16-bit re-read and the status flag are all unchanged.

The counter value itself is never predicted. Each capture edge is driven in the same cycle as a counter high-byte read, so the captured value must equal the counter snapshot. Compare targets are set as an offset from a fresh snapshot.

Counter wrap would take a quarter million cycles at the default prescale. A second instance with prescale 1 shares the bus and reaches the wrap within the run.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned N_FLAG = 2 * N_CH + 1;

  typedef enum logic [ADDR_W-1:0] {
    A_IEN    = 4'd0,
    A_CFG    = 4'd1,
    A_STAT   = 4'd2,
    A_CNT_H  = 4'd3,
    A_CNT_L  = 4'd4,
    A_CAP0_H = 4'd5,
    A_CAP0_L = 4'd6,
    A_CAP1_H = 4'd7,
    A_CAP1_L = 4'd8,
    A_CMP0_H = 4'd9,
    A_CMP0_L = 4'd10,
    A_CMP1_H = 4'd11,
    A_CMP1_L = 4'd12
  } reg_addr_e;

  // status / enable bit positions
  localparam int unsigned F_CAP = 0;
  localparam int unsigned F_CMP = N_CH;
  localparam int unsigned F_OVF = 2 * N_CH;
endpackage

// File: rtl/cc_timebase.sv
module cc_timebase #(
  parameter int unsigned PRE_LOG2 = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             moved_o,
  output logic             wrap_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             moved_q;

  generate
    if (PRE_LOG2 == 0) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_q + PRE_LOG2'(1);
      end
      assign tick = &pre_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      moved_q <= 1'b0;
    end else begin
      moved_q <= tick;
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o   = cnt_q;
  assign moved_o = moved_q;
  assign wrap_o  = tick & (&cnt_q);
endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             acc_lo_i,
  output logic [CNT_W-1:0] val_o,
  output logic             hit_o
);
  logic             pin_q;
  logic             hold_q;
  logic             edge_seen;
  logic [CNT_W-1:0] val_q;

  assign edge_seen = rise_i ? (pin_i & ~pin_q) : (~pin_i & pin_q);
  // frozen from the high-byte read cycle until the low-byte access
  assign hit_o     = edge_seen & ~hold_q & ~rd_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      hold_q <= 1'b0;
      val_q  <= '0;
    end else begin
      pin_q <= pin_i;
      if (rd_hi_i)       hold_q <= 1'b1;
      else if (acc_lo_i) hold_q <= 1'b0;
      if (hit_o) val_q <= cnt_i;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              moved_i,
  input  logic              level_i,
  output logic [CNT_W-1:0]  val_o,
  output logic              match_o,
  output logic              pin_o
);
  logic [CNT_W-1:0] val_q;
  logic             inhibit_q;
  logic             pin_q;

  assign match_o = ~inhibit_q & moved_i & (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q     <= '0;
      inhibit_q <= 1'b1;
      pin_q     <= 1'b0;
    end else begin
      if (wr_hi_i) begin
        val_q[CNT_W-1:BYTE_W] <= wdata_i;
        inhibit_q             <= 1'b1;
      end
      if (wr_lo_i) begin
        val_q[BYTE_W-1:0] <= wdata_i;
        inhibit_q         <= 1'b0;
      end
      if (match_o) pin_q <= level_i;
    end
  end

  assign val_o = val_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   cap_i,
  output logic [N_CH-1:0]   cmp_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]             cnt_w;
  logic                         moved_w;
  logic                         wrap_w;
  logic [BYTE_W-1:0]            ien_q;
  logic [BYTE_W-1:0]            cfg_q;
  logic [N_FLAG-1:0]            stat_q;
  logic [N_FLAG-1:0]            arm_q;
  logic [N_FLAG-1:0]            set_v;
  logic [N_FLAG-1:0]            lo_acc;
  logic [BYTE_W-1:0]            lo_buf_q;
  logic                         lo_pend_q;
  logic [N_CH-1:0][CNT_W-1:0]   cap_val;
  logic [N_CH-1:0][CNT_W-1:0]   cmp_val;
  logic [N_CH-1:0]              cap_hit;
  logic [N_CH-1:0]              cmp_hit;
  logic                         stat_rd;
  logic                         acc;

  assign acc     = rd_i | wr_i;
  assign stat_rd = rd_i && (addr_i == A_STAT);

  cc_timebase #(.PRE_LOG2(PRE_LOG2), .CNT_W(CNT_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .moved_o(moved_w),
    .wrap_o (wrap_w)
  );

  generate
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
      localparam logic [ADDR_W-1:0] CAP_H = ADDR_W'(A_CAP0_H + 2 * k);
      localparam logic [ADDR_W-1:0] CAP_L = ADDR_W'(A_CAP0_L + 2 * k);
      localparam logic [ADDR_W-1:0] CMP_H = ADDR_W'(A_CMP0_H + 2 * k);
      localparam logic [ADDR_W-1:0] CMP_L = ADDR_W'(A_CMP0_L + 2 * k);

      cc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (cap_i[k]),
        .rise_i  (cfg_q[k]),
        .cnt_i   (cnt_w),
        .rd_hi_i (rd_i && addr_i == CAP_H),
        .acc_lo_i(acc && addr_i == CAP_L),
        .val_o   (cap_val[k]),
        .hit_o   (cap_hit[k])
      );

      cc_compare #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_hi_i(wr_i && addr_i == CMP_H),
        .wr_lo_i(wr_i && addr_i == CMP_L),
        .wdata_i(wdata_i),
        .cnt_i  (cnt_w),
        .moved_i(moved_w),
        .level_i(cfg_q[N_CH+k]),
        .val_o  (cmp_val[k]),
        .match_o(cmp_hit[k]),
        .pin_o  (cmp_o[k])
      );

      assign lo_acc[F_CAP+k] = acc && addr_i == CAP_L;
      assign lo_acc[F_CMP+k] = acc && addr_i == CMP_L;
      assign set_v[F_CAP+k]  = cap_hit[k];
      assign set_v[F_CMP+k]  = cmp_hit[k];
    end
  endgenerate

  assign lo_acc[F_OVF] = acc && addr_i == A_CNT_L;
  assign set_v[F_OVF]  = wrap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q     <= '0;
      cfg_q     <= '0;
      stat_q    <= '0;
      arm_q     <= '0;
      lo_buf_q  <= '0;
      lo_pend_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_IEN) ien_q <= wdata_i;
      if (wr_i && addr_i == A_CFG) cfg_q <= wdata_i;
      // a new event wins over a clear in the same cycle
      stat_q <= set_v | (stat_q & ~(arm_q & lo_acc));
      arm_q  <= (arm_q | (stat_rd ? stat_q : '0)) & ~lo_acc;
      if (rd_i && addr_i == A_CNT_H) begin
        lo_buf_q  <= cnt_w[BYTE_W-1:0];
        lo_pend_q <= 1'b1;
      end else if (rd_i && addr_i == A_CNT_L) begin
        lo_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IEN:    rdata_o = ien_q;
      A_CFG:    rdata_o = cfg_q;
      A_STAT:   rdata_o = BYTE_W'(stat_q);
      A_CNT_H:  rdata_o = cnt_w[CNT_W-1:BYTE_W];
      A_CNT_L:  rdata_o = lo_pend_q ? lo_buf_q : cnt_w[BYTE_W-1:0];
      A_CAP0_H: rdata_o = cap_val[0][CNT_W-1:BYTE_W];
      A_CAP0_L: rdata_o = cap_val[0][BYTE_W-1:0];
      A_CAP1_H: rdata_o = cap_val[1][CNT_W-1:BYTE_W];
      A_CAP1_L: rdata_o = cap_val[1][BYTE_W-1:0];
      A_CMP0_H: rdata_o = cmp_val[0][CNT_W-1:BYTE_W];
      A_CMP0_L: rdata_o = cmp_val[0][BYTE_W-1:0];
      A_CMP1_H: rdata_o = cmp_val[1][CNT_W-1:BYTE_W];
      A_CMP1_L: rdata_o = cmp_val[1][BYTE_W-1:0];
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & ien_q[N_FLAG-1:0]);
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       rd_i,
  input logic                       wr_i,
  input logic [CNT_W-1:0]           cnt_w,
  input logic [N_FLAG-1:0]          stat_q,
  input logic [N_CH-1:0][CNT_W-1:0] cap_val,
  input logic                       irq_o
);
  logic hold0_q, pend0_q, arm0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold0_q <= 1'b0;
      pend0_q <= 1'b1;
      arm0_q  <= 1'b0;
    end else begin
      if (rd_i && addr_i == A_CAP0_H) hold0_q <= 1'b1;
      else if ((rd_i || wr_i) && addr_i == A_CAP0_L) hold0_q <= 1'b0;
      if (wr_i && addr_i == A_CMP0_H) pend0_q <= 1'b1;
      else if (wr_i && addr_i == A_CMP0_L) pend0_q <= 1'b0;
      if ((rd_i || wr_i) && addr_i == A_CAP0_L) arm0_q <= 1'b0;
      else if (rd_i && addr_i == A_STAT && stat_q[F_CAP]) arm0_q <= 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != $past(cnt_w)) |-> (cnt_w == CNT_W'($past(cnt_w) + 1'b1))); // R1

  generate
    if (PRE_LOG2 == 2) begin : g_div4
      AST_CNT_PRESCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_w != $past(cnt_w)) |->
          ($past(cnt_w) == $past(cnt_w, 2) && $past(cnt_w, 2) == $past(cnt_w, 3))); // R2
    end
  endgenerate

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold0_q |=> $stable(cap_val[0])); // R5

  AST_CMP_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[F_CMP]) |-> !$past(pend0_q)); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q == '0) |-> !irq_o); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_q[F_CAP]) |-> $past(arm0_q)); // R10
endmodule

bind cc_timer cc_timer_chk #(.PRE_LOG2(PRE_LOG2)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .cnt_w  (cnt_w),
  .stat_q (stat_q),
  .cap_val(cap_val),
  .irq_o  (irq_o)
);

// File: tb/cc_timer_tb.sv
`timescale 1ns/1ps
module cc_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_f;
  logic [1:0] cap = '0;
  logic [1:0] cmp, cmp_f;
  logic       irq, irq_f;
  int         errors = 0, checks = 0;
  int         cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  cc_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq));

  cc_timer #(.PRE_LOG2(0)) u_ovf (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata_f), .cap_i(cap), .cmp_o(cmp_f), .irq_o(irq_f));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d, output logic [7:0] df);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata; df = rdata_f;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic pin_op(input int k, input logic v);
    @(negedge clk); cap[k] = v;
    @(posedge clk); #1;
  endtask

  // counter high read, optionally with a capture pin change in the same cycle
  task automatic cnt_snap(input int k, input logic v, input bit drive, output logic [15:0] val);
    logic [7:0] h, l, x;
    @(negedge clk); addr = 4'd3; rd = 1'b1;
    if (drive) cap[k] = v;
    #1 h = rdata;
    @(posedge clk); #1 rd = 1'b0;
    bus_rd(4'd4, l, x);
    val = {h, l};
  endtask

  task automatic rd16(input logic [3:0] a_hi, output logic [15:0] val);
    logic [7:0] h, l, x;
    bus_rd(a_hi, h, x);
    bus_rd(a_hi + 4'd1, l, x);
    val = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1520000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  d, df;
    logic [15:0] v1, v2, c, old, t;
    logic [7:0]  h1;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset state
    bus_rd(4'd0, d, df); check("R11 ien", d, 0);
    bus_rd(4'd1, d, df); check("R11 cfg", d, 0);
    bus_rd(4'd2, d, df); check("R11 stat", d, 0);
    check("R11 cmp pins", cmp, 0);
    check("R11 irq", irq, 0);

    bus_wr(4'd1, 8'b0000_1101);  // cap0 rising, cap1 falling, both levels 1
    bus_wr(4'd0, 8'h01);         // only cap0 enabled

    // R2 rate: high reads 400 cycles apart
    cnt_snap(0, 0, 0, v1); idle(398); cnt_snap(0, 0, 0, v2);
    check("R2 divide by four", int'(16'(v2 - v1)), 100);

    // R1 writes ignored: high reads 4 cycles apart
    cnt_snap(0, 0, 0, v1); bus_wr(4'd3, 8'h00); bus_wr(4'd4, 8'h00); cnt_snap(0, 0, 0, v2);
    check("R1 counter read-only", int'(16'(v2 - v1)), 1);

    // R3 buffered low byte: high at T, low at T+1003, next high at T+1004
    bus_rd(4'd3, h1, df); idle(1002); bus_rd(4'd4, d, df);
    cnt_snap(0, 0, 0, v2);
    check("R3 coherent read", int'(16'(v2 - {h1, d})), 251);

    // R4 capture on rising edge, same cycle as a counter snapshot
    cnt_snap(0, 1, 1, v1);
    rd16(4'd5, c);
    check("R4 cap0 value", c, v1);
    check("R9 irq on enabled flag", irq, 1);

    // R10 low access without status read does not clear
    bus_rd(4'd6, d, df);
    check("R10 no clear unarmed", irq, 1);
    bus_rd(4'd2, d, df); check("R4 cap0 flag", d[0], 1);
    bus_rd(4'd6, d, df);
    check("R10 clear after status", irq, 0);
    bus_rd(4'd2, d, df); check("R10 stat bit0 cleared", d[0], 0);

    // R5 hold window
    old = c;
    bus_rd(4'd5, d, df);
    pin_op(0, 0); pin_op(0, 1);
    bus_rd(4'd6, d, df); check("R5 low byte held", d, old[7:0]);
    bus_rd(4'd2, d, df); check("R5 held edge sets no flag", d[0], 0);
    rd16(4'd5, c); check("R5 value kept", c, old);
    pin_op(0, 0);
    cnt_snap(0, 1, 1, v1);
    rd16(4'd5, c); check("R5 capture after release", c, v1);
    bus_rd(4'd2, d, df); bus_rd(4'd6, d, df);
    check("R10 cap0 cleared again", irq, 0);

    // R4 falling select: rising edge ignored, falling captured
    pin_op(1, 1);
    bus_rd(4'd2, d, df); check("R4 cap1 ignores rising", d[1], 0);
    cnt_snap(1, 0, 1, v1);
    rd16(4'd7, c); check("R4 cap1 falling value", c, v1);
    bus_rd(4'd2, d, df); check("R4 cap1 flag", d[1], 1);
    check("R9 cap1 masked", irq, 0);

    // R6/R7 compare 0
    cnt_snap(0, 0, 0, v1); t = v1 + 16'd20;
    bus_wr(4'd9, t[15:8]); bus_wr(4'd10, t[7:0]);
    idle(55);
    bus_rd(4'd2, d, df); check("R7 no early match", d[2], 0);
    check("R7 pin before match", cmp[0], 0);
    idle(40);
    bus_rd(4'd2, d, df); check("R7 cmp0 flag", d[2], 1);
    check("R7 cmp0 level", cmp[0], 1);
    rd16(4'd9, c); check("R11 cmp0 readback", c, t);  // accesses low: armed, clears
    bus_rd(4'd2, d, df); check("R10 cmp0 cleared", d[2], 0);

    // R6 inhibit on compare 1
    cnt_snap(0, 0, 0, v1); t = v1 + 16'd20;
    bus_wr(4'd11, t[15:8]); bus_wr(4'd12, t[7:0]); bus_wr(4'd11, t[15:8]);
    idle(120);
    bus_rd(4'd2, d, df); check("R6 inhibited no flag", d[3], 0);
    check("R6 inhibited pin", cmp[1], 0);
    cnt_snap(0, 0, 0, v1); t = v1 + 16'd20;
    bus_wr(4'd11, t[15:8]); bus_wr(4'd12, t[7:0]);
    idle(120);
    bus_rd(4'd2, d, df); check("R6 re-enabled flag", d[3], 1);
    check("R7 cmp1 level", cmp[1], 1);

    // R8 overflow on the undivided instance
    bus_rd(4'd2, d, df); check("R8 no early wrap", df[4], 0);
    while (cyc < 66000) @(posedge clk);
    #1;
    bus_wr(4'd0, 8'h10);
    bus_rd(4'd2, d, df);
    check("R8 wrap flag", df[4], 1);
    check("R8 divided instance no wrap", d[4], 0);
    check("R9 ovf irq", irq_f, 1);
    check("R9 masked flags quiet", irq, 0);
    bus_rd(4'd4, d, df);
    bus_rd(4'd2, d, df); check("R10 ovf cleared", df[4], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule